// File: doc/BRIEF.md
# Host Command and Completion Queue Register Block

This block is the device-facing register window of a storage controller's host interface. The host reaches it over a plain 32-bit memory-mapped bus in which every access takes one cycle. The host hands work to the device by writing command bus addresses to a request port. Those words queue in a request FIFO, and a device-side consumer takes them in arrival order. Going the other way, the device pushes completion tags into a reply FIFO. The host collects each tag by reading the reply port. When that FIFO is empty, the read returns all ones and the queue is left unchanged.

A reply interrupt tells the host that completions are waiting. It is gated by a mask register whose polarity is inverted: a set bit disables the interrupt, and writing zero enables it. An interrupt status register reports pending completions whether or not the mask is set. A variant parameter selects bit 3 or bit 2 as the position of both the mask bit and the pending bit. The window also holds a scratchpad word that reports device readiness, a doorbell of sticky bits that the host sets and the device clears, and two read-only configuration-table pointers supplied as parameters.

Top module: `hostq_regs`

## Requirements
- R1: A bus write to offset 0x40 pushes the 32-bit write data into the request FIFO. The device side sees the words on `req_data`, oldest first, while `req_valid` is high. Each cycle with `req_pop` high removes one word.
- R2: A bus read of offset 0x44 returns the oldest reply tag and removes it. When the reply FIFO is empty, the read returns 0xFFFFFFFF and removes nothing.
- R3: Each FIFO holds DEPTH (16) entries. A request-port write while the request FIFO is full is discarded, and `req_overflow` goes high and stays high until reset. The 16 stored words are not altered.
- R4: The mask register at offset 0x34 resets to the disable value: 0x08 for the default variant, 0x04 for variant B. It reads back what was last written. `irq` goes high one cycle after the reply FIFO is non-empty and the variant's mask bit is clear, and it is low otherwise. For the default variant, a written value of 0x04 leaves the interrupt enabled.
- R5: A read of the status register at offset 0x30 returns the variant's pending bit (bit 3 by default) set exactly when the reply FIFO is non-empty, whatever the mask holds. All other bits read as zero.
- R6: A read of the scratchpad at offset 0xB0 returns 0xFFFF0000 while `dev_ready` is high and 0x00000000 while it is low. Writes to it have no effect.
- R7: A write to the doorbell at offset 0x20 ORs the write data into sticky bits. The bits appear on `db_bits` and read back at 0x20. Each bit set in `db_clear` during a cycle clears the matching bit.
- R8: Reads of offsets 0xB4 and 0xB8 return the parameters CFG_TABLE_PTR and CFG_MEM_PTR. Writes to these offsets are ignored.
- R9: Reads of any other offset, including the request port, return zero. Writes to any other offset, including the reply port, change no state.
- R10: Reply tags pass through unchanged, including bit 1 (value 0x02), which marks a command that ended in error. A push while the reply FIFO is full is dropped, and `rpl_full` is high while 16 tags are held.
- R11: Read data appears on `bus_rdata` in the cycle after the read request. In every cycle that follows no read request, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | Request FIFO holds a word |
| req_data | output | 32 | Oldest command address |
| req_pop | input | 1 | Device consumes the oldest command |
| req_overflow | output | 1 | Sticky flag for a dropped request write |
| rpl_push | input | 1 | Device pushes a completion tag |
| rpl_tag | input | 32 | Completion tag to push |
| rpl_full | output | 1 | Reply FIFO is full |
| dev_ready | input | 1 | Device firmware is ready |
| db_clear | input | 32 | Per-bit doorbell clear from the device |
| db_bits | output | 32 | Sticky doorbell bits |
| irq | output | 1 | Reply interrupt to the host |

## Verification
A corrupted FIFO pointer or count shows at the ports on the very next access. A request word appears out of order or duplicated on `req_data`. A reply read returns a stale tag, or it returns all ones while tags are still held. A filled queue shows whether the count saturates at 16, because the 17th word is either lost cleanly or wraps over the oldest. A wrong mask or pending bit position shows up one cycle later on `irq` and in the status word. The doorbell is tested by setting bits, clearing them, and reading them back.

// File: rtl/hostq_pkg.sv
package hostq_pkg;
  localparam logic [7:0] OFS_DOORBELL = 8'h20;
  localparam logic [7:0] OFS_STATUS   = 8'h30;
  localparam logic [7:0] OFS_MASK     = 8'h34;
  localparam logic [7:0] OFS_REQ      = 8'h40;
  localparam logic [7:0] OFS_RPL      = 8'h44;
  localparam logic [7:0] OFS_SCRATCH  = 8'hB0;
  localparam logic [7:0] OFS_CFGTAB   = 8'hB4;
  localparam logic [7:0] OFS_CFGMEM   = 8'hB8;

  localparam logic [31:0] WORD_EMPTY = 32'hFFFF_FFFF;
  localparam logic [31:0] WORD_READY = 32'hFFFF_0000;

  typedef enum logic {VAR_A = 1'b0, VAR_B = 1'b1} irq_variant_e;
endpackage

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
  p_empty_no_pop_r2: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/hostq_irq.sv
module hostq_irq #(
  parameter int DW      = 32,
  parameter int IRQ_BIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mask_word,
  input  logic          pending,
  output logic          irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pending & ~mask_word[IRQ_BIT];
  end

  p_irq_masked_r4: assert property (@(posedge clk) disable iff (rst)
    mask_word[IRQ_BIT] |=> !irq_o);
  p_irq_needs_work_r4: assert property (@(posedge clk) disable iff (rst)
    !pending |=> !irq_o);
endmodule

// File: rtl/hostq_regs.sv
module hostq_regs
  import hostq_pkg::*;
#(
  parameter int            DEPTH         = 16,
  parameter irq_variant_e  VARIANT       = VAR_A,
  parameter logic [31:0]   CFG_TABLE_PTR = 32'h0000_1000,
  parameter logic [31:0]   CFG_MEM_PTR   = 32'h0000_2000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        req_valid,
  output logic [31:0] req_data,
  input  logic        req_pop,
  output logic        req_overflow,
  input  logic        rpl_push,
  input  logic [31:0] rpl_tag,
  output logic        rpl_full,
  input  logic        dev_ready,
  input  logic [31:0] db_clear,
  output logic [31:0] db_bits,
  output logic        irq
);
  localparam int DW      = 32;
  localparam int IRQ_BIT = (VARIANT == VAR_B) ? 2 : 3;
  localparam logic [DW-1:0] MASK_RESET = DW'(1) << IRQ_BIT;

  logic          rd_req, wr_req;
  logic          req_push, req_empty, req_full;
  logic          rpl_pop, rpl_empty;
  logic [DW-1:0] rpl_dout;
  logic [DW-1:0] mask_q, db_q, stat_w, rd_mux;

  assign rd_req = bus_sel & ~bus_wr;
  assign wr_req = bus_sel & bus_wr;

  assign req_push = wr_req && (bus_addr == OFS_REQ);
  assign rpl_pop  = rd_req && (bus_addr == OFS_RPL) && !rpl_empty;

  hostq_fifo #(.W(DW), .DEPTH(DEPTH)) u_req_fifo (
    .clk(clk), .rst(rst), .push(req_push), .din(bus_wdata),
    .pop(req_pop), .dout(req_data), .empty(req_empty), .full(req_full)
  );

  hostq_fifo #(.W(DW), .DEPTH(DEPTH)) u_rpl_fifo (
    .clk(clk), .rst(rst), .push(rpl_push), .din(rpl_tag),
    .pop(rpl_pop), .dout(rpl_dout), .empty(rpl_empty), .full(rpl_full)
  );

  assign req_valid = ~req_empty;
  assign db_bits   = db_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_overflow <= 1'b0;
      mask_q       <= MASK_RESET;
      db_q         <= '0;
    end else begin
      if (req_push && req_full) req_overflow <= 1'b1;
      if (wr_req && bus_addr == OFS_MASK) mask_q <= bus_wdata;
      db_q <= (db_q & ~db_clear) |
              ((wr_req && bus_addr == OFS_DOORBELL) ? bus_wdata : '0);
    end
  end

  always_comb begin
    stat_w          = '0;
    stat_w[IRQ_BIT] = ~rpl_empty;
  end

  always_comb begin
    case (bus_addr)
      OFS_DOORBELL: rd_mux = db_q;
      OFS_STATUS:   rd_mux = stat_w;
      OFS_MASK:     rd_mux = mask_q;
      OFS_RPL:      rd_mux = rpl_empty ? WORD_EMPTY : rpl_dout;
      OFS_SCRATCH:  rd_mux = dev_ready ? WORD_READY : '0;
      OFS_CFGTAB:   rd_mux = CFG_TABLE_PTR;
      OFS_CFGMEM:   rd_mux = CFG_MEM_PTR;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_req ? rd_mux : '0;
  end

  hostq_irq #(.DW(DW), .IRQ_BIT(IRQ_BIT)) u_irq (
    .clk(clk), .rst(rst), .mask_word(mask_q),
    .pending(~rpl_empty), .irq_o(irq)
  );

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    req_overflow |=> req_overflow);
  p_empty_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_addr == OFS_RPL && rpl_empty) |=> (bus_rdata == WORD_EMPTY));
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (bus_rdata == '0));
  p_db_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (|db_q) |=> ((db_q & $past(db_q & ~db_clear)) == $past(db_q & ~db_clear)));
endmodule

// File: tb/tb_hostq_regs.sv
`timescale 1ns/100ps
module tb_hostq_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid, req_pop = 1'b0, req_overflow;
  logic [31:0] req_data;
  logic        rpl_push = 1'b0, rpl_full;
  logic [31:0] rpl_tag = '0;
  logic        dev_ready = 1'b0;
  logic [31:0] db_clear = '0, db_bits;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hostq_regs dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_data(req_data), .req_pop(req_pop),
    .req_overflow(req_overflow), .rpl_push(rpl_push), .rpl_tag(rpl_tag),
    .rpl_full(rpl_full), .dev_ready(dev_ready), .db_clear(db_clear),
    .db_bits(db_bits), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic push_tag(input logic [31:0] t);
    @(negedge clk); rpl_push = 1; rpl_tag = t;
    @(negedge clk); rpl_push = 0;
  endtask

  task automatic pop_req(output logic v, output logic [31:0] d);
    @(negedge clk); v = req_valid; d = req_data; req_pop = 1;
    @(negedge clk); req_pop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R4 irq after reset", {31'b0, irq}, 0);
    chk("R1 req_valid after reset", {31'b0, req_valid}, 0);
    chk("R3 overflow after reset", {31'b0, req_overflow}, 0);
    bus_read(8'h34, d); chk("R4 mask reset value", d, 32'h08);
    bus_read(8'h30, d); chk("R5 status after reset", d, 0);
    @(negedge clk); chk("R11 idle rdata zero", bus_rdata, 0);
  endtask

  task automatic t_request_order();
    logic v; logic [31:0] d;
    bus_write(8'h40, 32'hA000_0010);
    bus_write(8'h40, 32'hA000_0020);
    bus_write(8'h40, 32'hA000_0030);
    for (int i = 0; i < 3; i++) begin
      pop_req(v, d);
      chk("R1 req_valid", {31'b0, v}, 1);
      chk("R1 req order", d, 32'hA000_0010 + 32'(16 * (i + 1)) - 32'h10);
    end
    chk("R1 req drained", {31'b0, req_valid}, 0);
  endtask

  task automatic t_overflow();
    logic v; logic [31:0] d;
    for (int i = 0; i < 16; i++) bus_write(8'h40, 32'h1000 + 32'(i));
    chk("R3 no overflow at 16", {31'b0, req_overflow}, 0);
    bus_write(8'h40, 32'hDEAD);
    chk("R3 overflow set", {31'b0, req_overflow}, 1);
    for (int i = 0; i < 16; i++) begin
      pop_req(v, d);
      chk("R3 stored word", d, 32'h1000 + 32'(i));
    end
    chk("R3 dropped word absent", {31'b0, req_valid}, 0);
    chk("R3 overflow sticky", {31'b0, req_overflow}, 1);
  endtask

  task automatic t_reply();
    logic [31:0] d;
    push_tag(32'h0000_1232);
    push_tag(32'h0000_4560);
    bus_read(8'h44, d); chk("R10 error bit kept", d, 32'h0000_1232);
    bus_read(8'h44, d); chk("R2 second tag", d, 32'h0000_4560);
    bus_read(8'h44, d); chk("R2 empty read", d, 32'hFFFF_FFFF);
    push_tag(32'h0000_0777);
    bus_read(8'h44, d); chk("R2 empty read popped nothing", d, 32'h0000_0777);
    bus_read(8'h40, d); chk("R9 request port reads zero", d, 0);
  endtask

  task automatic t_reply_full();
    logic [31:0] d;
    for (int i = 0; i < 17; i++) push_tag(32'h5000 + 32'(i));
    chk("R10 rpl_full", {31'b0, rpl_full}, 1);
    for (int i = 0; i < 16; i++) begin
      bus_read(8'h44, d);
      chk("R10 full-queue tag", d, 32'h5000 + 32'(i));
    end
    bus_read(8'h44, d); chk("R10 extra push dropped", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    push_tag(32'h0000_0002);
    @(negedge clk); chk("R4 masked irq low", {31'b0, irq}, 0);
    bus_read(8'h30, d); chk("R5 pending while masked", d, 32'h08);
    bus_write(8'h34, 32'h0);
    @(negedge clk); chk("R4 irq on after unmask", {31'b0, irq}, 1);
    bus_read(8'h34, d); chk("R4 mask readback", d, 0);
    bus_write(8'h34, 32'h08);
    @(negedge clk); chk("R4 irq off after mask", {31'b0, irq}, 0);
    bus_write(8'h34, 32'h04);
    @(negedge clk); chk("R4 other bit leaves irq on", {31'b0, irq}, 1);
    bus_read(8'h44, d); chk("R10 tag on irq path", d, 32'h2);
    @(negedge clk); chk("R4 irq off when drained", {31'b0, irq}, 0);
    bus_read(8'h30, d); chk("R5 status cleared", d, 0);
    bus_write(8'h34, 32'h08);
  endtask

  task automatic t_scratch();
    logic [31:0] d;
    bus_read(8'hB0, d); chk("R6 not ready", d, 0);
    dev_ready = 1;
    bus_write(8'hB0, 32'h1234);
    bus_read(8'hB0, d); chk("R6 ready", d, 32'hFFFF_0000);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    bus_write(8'h20, 32'h05);
    bus_read(8'h20, d); chk("R7 doorbell set", d, 32'h05);
    bus_write(8'h20, 32'h30);
    chk("R7 doorbell sticky or", db_bits, 32'h35);
    @(negedge clk); db_clear = 32'h04;
    @(negedge clk); db_clear = 0;
    chk("R7 device clear", db_bits, 32'h31);
    bus_read(8'h20, d); chk("R7 readback after clear", d, 32'h31);
  endtask

  task automatic t_cfg_unmapped();
    logic [31:0] d;
    bus_write(8'hB4, 32'h9999);
    bus_read(8'hB4, d); chk("R8 table pointer", d, 32'h0000_1000);
    bus_read(8'hB8, d); chk("R8 memory pointer", d, 32'h0000_2000);
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_write(8'h44, 32'h1234_5678);
    bus_read(8'h50, d); chk("R9 unmapped read", d, 0);
    bus_read(8'h34, d); chk("R9 mask untouched", d, 32'h08);
    bus_read(8'h20, d); chk("R9 doorbell untouched", d, 32'h31);
    bus_read(8'h44, d); chk("R9 reply port write ignored", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_request_order();
    t_overflow();
    t_reply();
    t_reply_full();
    t_irq();
    t_scratch();
    t_doorbell();
    t_cfg_unmapped();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule